// File: doc/BRIEF.md
# Dual Cascadable Interval Timer

Two 16-bit down-counters, called A and B, sit behind a small byte-wide register window. Each counter has a reload latch and a control byte. When a timer reaches zero and is asked to count once more, it reloads from its latch and raises a one-cycle underflow pulse. An external interrupt controller receives that pulse. A timer either keeps running (continuous) or stops itself after the first underflow (one-shot).

Timer A counts either system clock cycles or rising edges of an external count input. Timer B has the same two sources and two more: the underflows of timer A, or the underflows of timer A taken only while the count input is high. These let the two timers act as one 32-bit interval counter, or as a gated event counter. The count input is synchronised internally, so any asynchronous signal may drive it.

Software sets the latches through byte writes. It starts, stops or force-loads each timer through its control byte, and reads the live counter values back through the same window. Reads have no side effects.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset, both counters and both latches hold 0xFFFF, and both control bytes read 0x00.
- R2: A write to offset 4 or 6 sets the latch low byte of A or B, and offset 5 or 7 sets the high byte. A high-byte write also copies the whole latch into the counter when that timer's start bit (control bit 0) is 0. While the start bit is 1, the counter is left unchanged.
- R3: Writing control bit 4 as 1 (control A at offset 0x0E, control B at 0x0F) copies the latch into the counter. Bit 4 always reads back as 0. All other control bits read back as written.
- R4: In continuous mode (bit 3 = 0) with start = 1, a timer decrements once per count event. A count event while the counter is 0 reloads the latch in place of the decrement. The underflow output is then high for exactly one cycle, so the period is latch+1 events.
- R5: In one-shot mode (bit 3 = 1), an underflow also clears the timer's own start bit. The counter then holds the latch value.
- R6: Writing a control byte with bit 0 = 0 reloads that timer's counter from its latch.
- R7: With control A bit 5 = 1, or control B bits 6:5 = 01, the timer counts rising edges of the count input after a two-flop synchroniser. It does not count clock cycles.
- R8: With control B bits 6:5 = 10, timer B decrements once for each timer A underflow, in the same cycle as that underflow.
- R9: With control B bits 6:5 = 11, timer B counts timer A underflows only while the synchronised count input is high.
- R10: Reading an offset in 0..15 that is not a counter or control byte returns 0. An address above 15 returns 0 on read and has no effect on write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | ADDR_W (8) | Register address |
| wrData | input | DATA_W (8) | Write data |
| rdData | output | DATA_W (8) | Combinational read data for `addr` |
| cntIn | input | 1 | External count input (asynchronous) |
| underflowA | output | 1 | One-cycle pulse on timer A underflow |
| underflowB | output | 1 | One-cycle pulse on timer B underflow |

## Verification
The bench measures the exact underflow cycle for a latch of 3. A design that reloaded on reaching zero, instead of on the next count, would pulse one cycle early and run with a period of latch rather than latch+1. It writes a latch high byte while a timer runs, and then force-loads. A design that always loaded on the high byte, or stored the strobe bit, shows a wrong counter or a wrong control read-back. In gated cascade mode it holds the count input low while timer A underflows repeatedly, and sends aliased addresses above 15. These catch a design that ignores the gate or truncates the address.

// File: rtl/dit_pkg.sv
package dit_pkg;

  // Per-timer strobes from control to datapath
  typedef struct packed {
    logic latchLoWr;
    logic latchHiWr;
    logic load;
    logic tick;
  } tmrStb_t;

  localparam logic [3:0] OFF_A_LO = 4'h4;
  localparam logic [3:0] OFF_A_HI = 4'h5;
  localparam logic [3:0] OFF_B_LO = 4'h6;
  localparam logic [3:0] OFF_B_HI = 4'h7;
  localparam logic [3:0] OFF_CR_A = 4'hE;
  localparam logic [3:0] OFF_CR_B = 4'hF;

  localparam int BIT_START   = 0;
  localparam int BIT_ONESHOT = 3;
  localparam int BIT_FORCE   = 4;
  localparam int BIT_SRC_LO  = 5;
  localparam int BIT_SRC_HI  = 6;

endpackage

// File: rtl/dit_counter.sv
module dit_counter
  import dit_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrStb_t           stb,
  input  logic [DATA_W-1:0] wrData,
  output logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  latch,
  output logic              uflow,
  output logic              uflowPulse
);

  logic [CNT_W-1:0] latchNext;

  always_comb begin
    latchNext = latch;
    if (stb.latchLoWr) latchNext[DATA_W-1:0] = wrData;
    if (stb.latchHiWr) latchNext[CNT_W-1:DATA_W] = wrData;
  end

  // A count request at zero becomes a reload; a load strobe overrides it
  assign uflow = stb.tick && !stb.load && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latch      <= '1;
      cnt        <= '1;
      uflowPulse <= 1'b0;
    end else begin
      latch      <= latchNext;
      uflowPulse <= uflow;
      if (stb.load)       cnt <= latchNext;
      else if (uflow)     cnt <= latch;
      else if (stb.tick)  cnt <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/dit_datapath.sv
module dit_datapath
  import dit_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrStb_t           stbA,
  input  tmrStb_t           stbB,
  input  logic [DATA_W-1:0] wrData,
  output logic [CNT_W-1:0]  cntA,
  output logic [CNT_W-1:0]  cntB,
  output logic [CNT_W-1:0]  latchA,
  output logic [CNT_W-1:0]  latchB,
  output logic              uflowA,
  output logic              uflowB,
  output logic              pulseA,
  output logic              pulseB
);

  dit_counter #(.DATA_W(DATA_W)) tmrA_i (
    .clk(clk), .rstN(rstN), .stb(stbA), .wrData(wrData),
    .cnt(cntA), .latch(latchA), .uflow(uflowA), .uflowPulse(pulseA)
  );

  dit_counter #(.DATA_W(DATA_W)) tmrB_i (
    .clk(clk), .rstN(rstN), .stb(stbB), .wrData(wrData),
    .cnt(cntB), .latch(latchB), .uflow(uflowB), .uflowPulse(pulseB)
  );

endmodule

// File: rtl/dit_ctrl.sv
module dit_ctrl
  import dit_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              cntIn,
  input  logic              uflowA,
  input  logic              uflowB,
  input  logic [CNT_W-1:0]  cntA,
  input  logic [CNT_W-1:0]  cntB,
  output tmrStb_t           stbA,
  output tmrStb_t           stbB,
  output logic [DATA_W-1:0] crA,
  output logic [DATA_W-1:0] crB,
  output logic [DATA_W-1:0] rdData
);

  logic       inRange;
  logic [3:0] off;
  logic       cntMeta, cntSync, cntPrev, cntEdge;
  logic       hitALo, hitAHi, hitBLo, hitBHi, hitCrA, hitCrB;

  assign inRange = (addr >> 4) == '0;
  assign off     = addr[3:0];

  assign hitALo = wrEn && inRange && (off == OFF_A_LO);
  assign hitAHi = wrEn && inRange && (off == OFF_A_HI);
  assign hitBLo = wrEn && inRange && (off == OFF_B_LO);
  assign hitBHi = wrEn && inRange && (off == OFF_B_HI);
  assign hitCrA = wrEn && inRange && (off == OFF_CR_A);
  assign hitCrB = wrEn && inRange && (off == OFF_CR_B);

  // Two-flop synchroniser plus edge history
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntMeta <= 1'b0;
      cntSync <= 1'b0;
      cntPrev <= 1'b0;
    end else begin
      cntMeta <= cntIn;
      cntSync <= cntMeta;
      cntPrev <= cntSync;
    end
  end
  assign cntEdge = cntSync && !cntPrev;

  logic ctrlLoadA, ctrlLoadB;
  assign ctrlLoadA = hitCrA && (wrData[BIT_FORCE] || !wrData[BIT_START]);
  assign ctrlLoadB = hitCrB && (wrData[BIT_FORCE] || !wrData[BIT_START]);

  always_comb begin
    stbA.latchLoWr = hitALo;
    stbA.latchHiWr = hitAHi;
    stbA.load      = (hitAHi && !crA[BIT_START]) || ctrlLoadA;
    stbA.tick      = crA[BIT_START] && (crA[BIT_SRC_LO] ? cntEdge : 1'b1);

    stbB.latchLoWr = hitBLo;
    stbB.latchHiWr = hitBHi;
    stbB.load      = (hitBHi && !crB[BIT_START]) || ctrlLoadB;
    unique case (crB[BIT_SRC_HI:BIT_SRC_LO])
      2'b00:   stbB.tick = crB[BIT_START];
      2'b01:   stbB.tick = crB[BIT_START] && cntEdge;
      2'b10:   stbB.tick = crB[BIT_START] && uflowA;
      default: stbB.tick = crB[BIT_START] && uflowA && cntSync;
    endcase
  end

  localparam logic [DATA_W-1:0] FORCE_MASK = ~(DATA_W'(1) << BIT_FORCE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crA <= '0;
      crB <= '0;
    end else begin
      if (hitCrA)                         crA <= wrData & FORCE_MASK;
      else if (uflowA && crA[BIT_ONESHOT]) crA[BIT_START] <= 1'b0;
      if (hitCrB)                         crB <= wrData & FORCE_MASK;
      else if (uflowB && crB[BIT_ONESHOT]) crB[BIT_START] <= 1'b0;
    end
  end

  always_comb begin
    rdData = '0;
    if (inRange) begin
      unique case (off)
        OFF_A_LO: rdData = cntA[DATA_W-1:0];
        OFF_A_HI: rdData = cntA[CNT_W-1:DATA_W];
        OFF_B_LO: rdData = cntB[DATA_W-1:0];
        OFF_B_HI: rdData = cntB[CNT_W-1:DATA_W];
        OFF_CR_A: rdData = crA;
        OFF_CR_B: rdData = crB;
        default:  rdData = '0;
      endcase
    end
  end

endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
  import dit_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              cntIn,
  output logic              underflowA,
  output logic              underflowB
);

  tmrStb_t           stbA, stbB;
  logic [DATA_W-1:0] crA, crB;
  logic [CNT_W-1:0]  cntA, cntB, latchA, latchB;
  logic              uflowA, uflowB;

  dit_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .cntIn(cntIn), .uflowA(uflowA), .uflowB(uflowB),
    .cntA(cntA), .cntB(cntB), .stbA(stbA), .stbB(stbB),
    .crA(crA), .crB(crB), .rdData(rdData)
  );

  dit_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .stbA(stbA), .stbB(stbB), .wrData(wrData),
    .cntA(cntA), .cntB(cntB), .latchA(latchA), .latchB(latchB),
    .uflowA(uflowA), .uflowB(uflowB),
    .pulseA(underflowA), .pulseB(underflowB)
  );

endmodule

// File: rtl/dit_checker.sv
module dit_checker #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic              underflowA,
  input logic              underflowB,
  input logic [DATA_W-1:0] crA,
  input logic [DATA_W-1:0] crB,
  input logic [CNT_W-1:0]  cntA,
  input logic [CNT_W-1:0]  latchA
);

  localparam logic [ADDR_W-1:0] AD_CR_A = ADDR_W'(14);
  localparam logic [ADDR_W-1:0] AD_CR_B = ADDR_W'(15);
  localparam logic [ADDR_W-1:0] AD_TOP  = ADDR_W'(15);
  localparam logic [DATA_W-1:0] NO_FORCE = ~(DATA_W'(1) << 4);

  // R3
  ctrl_a_readback_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == AD_CR_A) |=> crA == ($past(wrData) & NO_FORCE));

  // R3
  ctrl_b_readback_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == AD_CR_B) |=> crB == ($past(wrData) & NO_FORCE));

  // R6
  stop_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == AD_CR_A && (!wrData[0] || wrData[4])) |=> cntA == latchA);

  // R4
  underflow_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (underflowA && !$past(wrEn)) |-> cntA == latchA);

  // R4
  stopped_a_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(crA[0]) |-> !underflowA);

  // R4
  stopped_b_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(crB[0]) |-> !underflowB);

  // R5
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (underflowA && $past(crA[3]) && !$past(wrEn)) |-> !crA[0]);

  // R10
  out_of_range_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addr > AD_TOP) |-> rdData == '0);

endmodule

bind dual_interval_timer dit_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/dual_interval_timer_tb_top.sv
module dual_interval_timer_tb_top;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rstN;
  logic       wrEn;
  logic [7:0] addr;
  logic [7:0] wrData;
  logic [7:0] rdData;
  logic       cntIn;
  logic       underflowA;
  logic       underflowB;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    int         kind;   // 0 register read, 1 underflowA, 2 underflowB
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t sbq[$];

  always #(CLK_P/2) clk = ~clk;

  dual_interval_timer dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .cntIn(cntIn), .underflowA(underflowA), .underflowB(underflowB)
  );

  // Monitor: compares queued expectations away from the active edge
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = sbq.pop_front();
      case (it.kind)
        0:       act = rdData;
        1:       act = {7'b0, underflowA};
        default: act = {7'b0, underflowB};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0; addr = 8'h0;
  endtask

  task automatic expect_item(int kind, logic [7:0] a, logic [7:0] e, string tag);
    item_t it;
    addr = a;
    it.kind = kind; it.exp = e; it.tag = tag;
    sbq.push_back(it);
    wait (sbq.size() == 0);
    @(posedge clk); #1;
  endtask

  task automatic pulse_cnt(int n);
    for (int i = 0; i < n; i++) begin
      cntIn = 1'b1; idle(4);
      cntIn = 1'b0; idle(4);
    end
  endtask

  initial begin
    rstN = 1'b0; wrEn = 1'b0; addr = 8'h0; wrData = 8'h0; cntIn = 1'b0;
    idle(3);
    rstN = 1'b1;
    idle(1);

    // R1 reset state
    expect_item(0, 8'h04, 8'hFF, "R1 A lo");
    expect_item(0, 8'h05, 8'hFF, "R1 A hi");
    expect_item(0, 8'h06, 8'hFF, "R1 B lo");
    expect_item(0, 8'h07, 8'hFF, "R1 B hi");
    expect_item(0, 8'h0E, 8'h00, "R1 ctrl A");
    expect_item(0, 8'h0F, 8'h00, "R1 ctrl B");

    // R10 unused offsets and out-of-range addresses
    expect_item(0, 8'h00, 8'h00, "R10 offset 0");
    expect_item(0, 8'h03, 8'h00, "R10 offset 3");
    wr(8'h15, 8'h12);
    expect_item(0, 8'h05, 8'hFF, "R10 write 0x15 ignored");
    expect_item(0, 8'h14, 8'h00, "R10 read 0x14");
    wr(8'h1E, 8'h01);
    expect_item(0, 8'h0E, 8'h00, "R10 write 0x1E ignored");

    // R3 force load of reset latch, strobe reads 0
    wr(8'h0E, 8'h10);
    expect_item(0, 8'h0E, 8'h00, "R3 force bit reads 0");
    expect_item(0, 8'h04, 8'hFF, "R1 latch reset value");

    // R2 stopped latch writes
    wr(8'h04, 8'h03);
    expect_item(0, 8'h04, 8'hFF, "R2 lo write no load");
    wr(8'h05, 8'h00);
    expect_item(0, 8'h04, 8'h03, "R2 hi write loads lo");
    expect_item(0, 8'h05, 8'h00, "R2 hi write loads hi");

    // R4 continuous, latch 3: underflow at 4th edge after start
    wr(8'h0E, 8'h01);
    idle(3);
    expect_item(1, 8'h00, 8'h00, "R4 no early underflow");
    expect_item(1, 8'h00, 8'h01, "R4 first underflow");
    idle(2);
    expect_item(1, 8'h00, 8'h00, "R4 gap");
    expect_item(1, 8'h00, 8'h01, "R4 period latch+1");
    // R6 stop reloads (counter is 2 here)
    wr(8'h0E, 8'h00);
    expect_item(0, 8'h04, 8'h03, "R6 stop reload");

    // R5 one-shot
    wr(8'h0E, 8'h09);
    idle(3);
    expect_item(1, 8'h00, 8'h00, "R5 before underflow");
    expect_item(1, 8'h00, 8'h01, "R5 underflow");
    expect_item(0, 8'h0E, 8'h08, "R5 start cleared");
    expect_item(0, 8'h04, 8'h03, "R5 counter holds latch");

    // R2 running hi write does not load; R3 force load
    wr(8'h06, 8'h05);
    wr(8'h07, 8'h00);
    wr(8'h0F, 8'h41);
    wr(8'h06, 8'h22);
    wr(8'h07, 8'h11);
    expect_item(0, 8'h06, 8'h05, "R2 running no load lo");
    expect_item(0, 8'h07, 8'h00, "R2 running no load hi");
    wr(8'h0F, 8'h51);
    expect_item(0, 8'h0F, 8'h41, "R3 ctrl B readback");
    expect_item(0, 8'h06, 8'h22, "R3 force load lo");
    expect_item(0, 8'h07, 8'h11, "R3 force load hi");

    // R8 cascade: A latch 1, B latch 2
    wr(8'h04, 8'h01);
    wr(8'h05, 8'h00);
    wr(8'h06, 8'h02);
    wr(8'h07, 8'h00);
    wr(8'h0F, 8'h51);
    wr(8'h0E, 8'h01);
    idle(5);
    expect_item(2, 8'h00, 8'h00, "R8 B not yet");
    expect_item(2, 8'h00, 8'h01, "R8 B underflow on 3rd A underflow");
    wr(8'h0E, 8'h00);
    wr(8'h0F, 8'h00);

    // R9 gated cascade
    wr(8'h0F, 8'h61);
    wr(8'h0E, 8'h01);
    idle(20);
    wr(8'h0E, 8'h00);
    expect_item(0, 8'h06, 8'h02, "R9 gate low blocks");
    cntIn = 1'b1;
    idle(4);
    wr(8'h0E, 8'h01);
    idle(3);
    wr(8'h0E, 8'h00);
    expect_item(0, 8'h06, 8'h01, "R9 gate high counts");
    wr(8'h0F, 8'h00);

    // R7 edge counting
    cntIn = 1'b0;
    idle(4);
    wr(8'h04, 8'h0A);
    wr(8'h05, 8'h00);
    wr(8'h0E, 8'h21);
    idle(6);
    expect_item(0, 8'h04, 8'h0A, "R7 A ignores clocks");
    pulse_cnt(3);
    expect_item(0, 8'h04, 8'h07, "R7 A counts edges");
    wr(8'h0E, 8'h00);
    wr(8'h06, 8'h04);
    wr(8'h07, 8'h00);
    wr(8'h0F, 8'h21);
    pulse_cnt(2);
    expect_item(0, 8'h06, 8'h02, "R7 B counts edges");
    wr(8'h0F, 8'h00);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule